// File: doc/BRIEF.md
# Partially Reset Datapath Pipeline

This block is a fixed-latency datapath pipeline with a small controller in front of it, built around a minimal-reset policy. Only registers that carry state through feedback are reset: the controller state, the conditionally loaded offset register, every stage's valid flag, and the output stage. The data registers of the head and middle stages have no reset. They load from their predecessor on every clock, so incoming data flushes them.

The controller has three states: start, load and run. Reset and a low `en` both force the start state, and the start state clears the offset register. With `en` high, the controller moves to load. There the first valid beat is kept as the session offset and is not passed on. In run, each valid beat enters the pipeline. The head stage adds the offset, and every later stage adds one. A beat therefore leaves with `in_data + offset + (STAGES-1)` after a fixed latency. Reset is synchronous and active low. It must be held for at least `STAGES` rising edges with `in_data` defined, so that every unreset stage holds a defined value when it releases.

Top module: `lean_rst_pipe`

## Requirements
- R1: At every rising edge where `rst_n` is 0, the output stage is cleared, so `out_valid` reads 0 and `out_data` reads 0 after that edge.
- R2: Reset clears the valid flag of every stage, so a beat that is in flight when reset is asserted never appears at the outputs.
- R3: The head and middle data stages have no reset and load on every edge whatever the valid flags hold. After `rst_n` has been low for at least `STAGES` edges with `in_data` defined, `out_data` is defined from the first edge after release. While `out_valid` is 0, `out_data` shows the `in_data` sampled `STAGES-1` edges earlier plus the offset plus `STAGES-1`. In the start state the offset is 0.
- R4: In the start state with `en` high, the controller moves to load on the next edge. In load, the first beat with `in_valid` 1 is stored as the offset, is never emitted, and moves the controller to run.
- R5: In run with `en` high, a beat sampled at rising edge k appears with `out_valid` 1 after edge k+STAGES-1, with `out_data` = (`in_data` + offset + STAGES-1) mod 2^DW. Beats keep their order and their spacing.
- R6: A beat offered while `en` is low, or while the controller is in start, is discarded and produces no `out_valid`.
- R7: `en` low at an edge puts the controller into the start state from any state, so the beat offered at that edge is dropped. After `en` rises again, the first valid beat becomes the new offset.
- R8: A beat already in the pipeline completes with the offset it entered with, even if `en` falls or a new offset is loaded while it travels. The offset does not change while the controller stays in run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, hold for at least STAGES edges |
| en | input | 1 | Enable; low returns the controller to its start state |
| in_valid | input | 1 | Input beat qualifier |
| in_data | input | DW | Input beat data; must be defined while reset is held |
| out_valid | output | 1 | Output beat qualifier |
| out_data | output | DW | Output beat data |

## Verification
Two functions can land on the same edge: the last beat of an old session leaving the pipeline, and the controller loading a new offset for the next session. The bench sends two beats, drops `en` for a single cycle while offering a beat that must be lost, and then supplies the new offset at once. This places the old beat's exit on the same edge as the offset load. The bench judges the result by exact exit cycle and value. The old beats must carry the old offset, the dropped beat and the offset beat must never appear, and the next beat must carry the new offset.

// File: rtl/lrp_pkg.sv
// Package: shared types for the partially reset pipeline.
// Assumes: nothing beyond being compiled before its users.
package lrp_pkg;

    // Controller states; ST_START is the state reset forces.
    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } lrp_state_e;

endpackage

// File: rtl/lrp_ctrl.sv
// Module: lrp_ctrl
// Sequences start -> load -> run. Holds the session offset, which is
// loaded once per session in the load state. Decides which input beats
// enter the pipeline.
// Assumes: synchronous active-low reset. Reset and a low enable share the
// start-state condition. The start state clears the offset.
module lrp_ctrl
    import lrp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output lrp_state_e    state,
    output logic [DW-1:0] bias,
    output logic          accept
);

    logic go_start;

    // Reset folded into the start condition together with disable.
    assign go_start = !rst_n || !en;

    // State register: feedback, so always reset.
    always_ff @(posedge clk) begin
        if (go_start) begin
            state <= ST_START;
        end else begin
            case (state)
                ST_START: state <= ST_LOAD;
                ST_LOAD:  if (in_valid) state <= ST_RUN;
                ST_RUN:   state <= ST_RUN;
                default:  state <= ST_START;
            endcase
        end
    end

    // Offset hold register: conditionally loaded, so reset and cleared at start.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_START) begin
            bias <= '0;
        end else if (state == ST_LOAD && en && in_valid) begin
            bias <= in_data;
        end
    end

    // Beats enter the datapath only while running and enabled.
    assign accept = en && in_valid && (state == ST_RUN);

endmodule

// File: rtl/lrp_stage.sv
// Module: lrp_stage
// One pipeline stage: the data register adds STEP to its input on every
// edge, and the valid flag follows its input.
// Assumes: the valid flag is always reset. The data register is reset only
// when RST_DATA is set (output stage); otherwise the flow of input flushes it.
module lrp_stage #(
    parameter int DW       = 8,
    parameter int STEP     = 0,
    parameter bit RST_DATA = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] dat_i,
    output logic          vld_o,
    output logic [DW-1:0] dat_o
);

    localparam logic [DW-1:0] STEP_W = DW'(STEP);

    // Valid flag: reset in every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    if (RST_DATA) begin : g_rst_data
        // Output-stage data: reset so outputs are known during reset.
        always_ff @(posedge clk) begin
            if (!rst_n) dat_o <= '0;
            else        dat_o <= dat_i + STEP_W;
        end
    end else begin : g_free_data
        // Middle-stage data: no reset, loads on every edge.
        always_ff @(posedge clk) begin
            dat_o <= dat_i + STEP_W;
        end
    end

endmodule

// File: rtl/lean_rst_pipe.sv
// Module: lean_rst_pipe (top)
// A controller feeds a STAGES-deep datapath. The head stage adds the
// session offset, and each later stage adds one.
// Assumes: STAGES >= 2. rst_n is held low for at least STAGES edges with
// in_data defined, so the unreset data stages are flushed by release.
module lean_rst_pipe
    import lrp_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int LAST = STAGES - 1;

    lrp_state_e    ctrl_state;
    logic [DW-1:0] bias_q;
    logic          accept;

    logic [STAGES-1:0] stg_v;
    logic [DW-1:0]     stg_d [STAGES];

    lrp_ctrl #(.DW(DW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .state    (ctrl_state),
        .bias     (bias_q),
        .accept   (accept)
    );

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic          vin;
        logic [DW-1:0] din;

        if (i == 0) begin : g_head
            // Head stage takes accepted beats plus the session offset.
            assign vin = accept;
            assign din = in_data + bias_q;
        end else begin : g_body
            // Later stages chain from their predecessor.
            assign vin = stg_v[i-1];
            assign din = stg_d[i-1];
        end

        lrp_stage #(
            .DW       (DW),
            .STEP     ((i == 0) ? 0 : 1),
            .RST_DATA (i == LAST)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vin),
            .dat_i (din),
            .vld_o (stg_v[i]),
            .dat_o (stg_d[i])
        );
    end

    assign out_valid = stg_v[LAST];
    assign out_data  = stg_d[LAST];

endmodule

// File: rtl/lrp_checker.sv
// Module: lrp_checker
// Properties for lean_rst_pipe, attached with bind.
// Assumes: sees the controller state and offset through bind connections.
module lrp_checker
    import lrp_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          in_valid,
    input lrp_state_e    state,
    input logic [DW-1:0] bias,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);

    localparam int CW = $clog2(STAGES + 1) + 1;

    logic [CW-1:0] rst_cnt  = '0;
    logic          flush_ok = 1'b0;
    logic          rst_seen;

    // Count consecutive reset edges; remember once a long-enough reset occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (int'(rst_cnt) < STAGES) rst_cnt <= rst_cnt + CW'(1);
            flush_ok <= flush_ok || (int'(rst_cnt) + 1 >= STAGES);
        end else begin
            rst_cnt <= '0;
        end
    end

    // Remember whether the last edge was a reset edge.
    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    // Outputs cleared after any reset edge.
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            AST_RESET_OUTPUTS: assert (out_valid == 1'b0 && out_data == '0) // R1
                else $error("AST_RESET_OUTPUTS");
        end
    end

    AST_FLUSHED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ok === 1'b1) |-> !$isunknown(out_data)) // R3
        else $error("AST_FLUSHED_DATA");

    AST_LOAD_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && en && in_valid) |=> (state == ST_RUN)) // R4
        else $error("AST_LOAD_TO_RUN");

    AST_DISABLE_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_START)) // R7
        else $error("AST_DISABLE_TO_START");

    AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en) |=> $stable(bias)) // R8
        else $error("AST_OFFSET_HELD");

endmodule

bind lean_rst_pipe lrp_checker #(.DW(DW), .STAGES(STAGES)) u_lrp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .in_valid  (in_valid),
    .state     (ctrl_state),
    .bias      (bias_q),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/lean_rst_pipe_tb.sv
// Bench: lean_rst_pipe_tb
// Directed scenarios, one task each. A negedge monitor matches output
// beats against an expected queue by value and exit cycle.
module lean_rst_pipe_tb;

    localparam int DW     = 8;
    localparam int STAGES = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int beats  = 0;
    bit finished = 1'b0;
    string mon_req = "R5";
    logic [DW-1:0] exp_bias;

    logic [DW-1:0] q_data[$];
    int            q_due[$];

    lean_rst_pipe #(.DW(DW), .STAGES(STAGES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offer one beat for the next edge; queue it if it must emerge.
    task automatic offer(input logic [DW-1:0] d, input bit expect_out);
        in_valid = 1'b1;
        in_data  = d;
        if (expect_out) begin
            q_data.push_back(d + exp_bias + DW'(STAGES - 1));
            q_due.push_back(cyc + STAGES);
        end
        tick();
        in_valid = 1'b0;
    endtask

    // Monitor: every output beat must match the queue head in value and cycle.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid !== 1'b0) begin
            beats++;
            if (q_data.size() == 0) begin
                check(1'b0, mon_req, "unexpected output beat", {24'd0, out_data}, 32'd0);
            end else begin
                logic [DW-1:0] ed;
                int            ec;
                ed = q_data.pop_front();
                ec = q_due.pop_front();
                check(out_data === ed, mon_req, "beat value", {24'd0, out_data}, {24'd0, ed});
                check(cyc == ec, mon_req, "beat exit cycle", cyc, ec);
            end
        end
    end

    // R1, R3: reset state, defined flush at release, free-running data path.
    task automatic t_reset_state();
        rst_n = 1'b0; en = 1'b0; in_valid = 1'b0; in_data = '0;
        tick();
        check(out_valid === 1'b0 && out_data === '0, "R1", "outputs during reset",
              {23'd0, out_valid, out_data}, 32'd0);
        repeat (STAGES - 1) tick();
        rst_n = 1'b1;
        tick();
        check(!$isunknown(out_data), "R3", "out_data defined at release", {24'd0, out_data}, STAGES - 1);
        check(out_data === DW'(STAGES - 1) && out_valid === 1'b0, "R3", "flushed value at release",
              {23'd0, out_valid, out_data}, STAGES - 1);
        in_data = 8'd10;
        repeat (STAGES) tick();
        check(out_data === DW'(10 + STAGES - 1) && out_valid === 1'b0, "R3", "idle data path tracks input",
              {23'd0, out_valid, out_data}, 10 + STAGES - 1);
        in_data = '0;
    endtask

    // R4, R5: load an offset, then stream beats with a gap and a wrap.
    task automatic t_stream();
        int b0;
        mon_req = "R5";
        b0 = beats;
        en = 1'b1;
        tick();
        offer(8'd5, 1'b0);
        exp_bias = 8'd5;
        offer(8'd1, 1'b1);
        offer(8'd2, 1'b1);
        offer(8'hFE, 1'b1);
        tick();
        offer(8'h80, 1'b1);
        repeat (STAGES + 2) tick();
        check(beats - b0 == 4, "R4", "offset beat not emitted", beats - b0, 4);
        check(q_data.size() == 0, "R5", "all beats delivered", q_data.size(), 0);
    endtask

    // R6: beats offered while disabled are discarded.
    task automatic t_drop();
        int b0;
        mon_req = "R6";
        b0 = beats;
        en = 1'b0;
        tick();
        offer(8'h55, 1'b0);
        offer(8'h66, 1'b0);
        offer(8'h77, 1'b0);
        repeat (STAGES + 1) tick();
        check(beats - b0 == 0, "R6", "no output while disabled", beats - b0, 0);
        check(out_valid === 1'b0, "R6", "out_valid low", out_valid, 0);
    endtask

    // R7, R8: old session beats drain while a new offset loads.
    task automatic t_overlap();
        int b0;
        mon_req = "R8";
        b0 = beats;
        en = 1'b1;
        tick();
        offer(8'd9, 1'b0);
        exp_bias = 8'd9;
        offer(8'h11, 1'b1);
        offer(8'h22, 1'b1);
        en = 1'b0;
        offer(8'h33, 1'b0);
        en = 1'b1;
        tick();
        offer(8'h40, 1'b0);
        exp_bias = 8'h40;
        offer(8'h01, 1'b1);
        repeat (STAGES + 2) tick();
        check(beats - b0 == 3, "R7", "dropped and offset beats absent", beats - b0, 3);
        check(q_data.size() == 0, "R8", "old and new session beats delivered", q_data.size(), 0);
    endtask

    // R2, R1, R3: reset while beats are in flight.
    task automatic t_reset_flight();
        int b0;
        mon_req = "R2";
        b0 = beats;
        offer(8'h10, 1'b0);
        offer(8'h20, 1'b0);
        rst_n = 1'b0;
        en    = 1'b0;
        in_data = '0;
        tick();
        check(out_valid === 1'b0 && out_data === '0, "R1", "outputs cleared mid-flight",
              {23'd0, out_valid, out_data}, 32'd0);
        repeat (STAGES - 1) begin
            tick();
            check(out_valid === 1'b0, "R2", "no valid while in reset", out_valid, 0);
        end
        rst_n = 1'b1;
        tick();
        check(out_data === DW'(STAGES - 1), "R3", "flushed value after second reset",
              {24'd0, out_data}, STAGES - 1);
        repeat (STAGES + 1) tick();
        check(beats - b0 == 0, "R2", "in-flight beats discarded", beats - b0, 0);
    endtask

    initial begin
        exp_bias = '0;
        rst_n = 1'b0; en = 1'b0; in_valid = 1'b0; in_data = '0;
        t_reset_state();
        t_stream();
        t_drop();
        t_overlap();
        t_reset_flight();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule